// File: doc/BRIEF.md
# Golden Packet Epoch Selector

In a deflection-routed 2D mesh, livelock freedom comes from giving one packet ID absolute priority for a fixed window of time. This block holds that notion. It keeps an epoch timer and a packet-ID register. It reports which packet is currently golden, and it pulses at the start of each epoch. It also classifies a presented flit header, giving a golden flag and a priority key that a deflection arbiter can compare directly.

Every router and endpoint holds an identical copy of the block. All copies leave reset together, so they agree on the golden ID in every cycle without exchanging messages. The golden ID walks through every (sender, transaction) pair in a fixed order and ignores traffic entirely. Within the golden packet, the key orders flits by sequence number. This gives a total order among golden flits, while every other flit gets the same lowest key.

With the default parameters there are 16 senders, 16 transaction slots and an epoch of 64 cycles. A full rotation through all 256 IDs therefore takes 16384 cycles. The epoch must exceed hop latency × (longest path + serialization), plus the side-buffer rescue time. For a 4x4 mesh this is 3 × (7 + 7) = 42 cycles plus 8 cycles of redirection, so 64 cycles is enough.

Top module: `golden_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `gold_id` is 0 and `epoch_start` is 1.
- R2: `gold_id` holds its value for exactly 64 clock cycles (2^EPOCH_W) per epoch, starting from the first cycle after reset.
- R3: `gold_id` is the concatenation {sender[3:0], transaction[3:0]}. At each epoch boundary it increments by one, so the transaction field (low bits) steps first and carries into the sender field. It wraps from 255 to 0.
- R4: `epoch_start` is 1 in the first cycle of each epoch, which is every 64th cycle, and is 0 in all other cycles.
- R5: `flit_golden` is 1 in the same cycle that `hdr_valid` is 1 and {`hdr_sender`, `hdr_txn`} equals `gold_id`. Otherwise it is 0.
- R6: `flit_key` is 4 bits. For a golden flit it is {1'b1, ~hdr_seq}, so a lower sequence number gives a larger key. For every other flit, and when `hdr_valid` is 0, it is 0.
- R7: Header traffic, whether it matches the golden ID or not, has no effect on `gold_id` or on `epoch_start` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A flit header is presented this cycle |
| hdr_sender | input | 4 | Sender node of the presented flit |
| hdr_txn | input | 4 | Transaction slot of the presented flit |
| hdr_seq | input | 3 | Sequence number of the flit within its packet |
| gold_id | output | 8 | Current golden packet ID {sender, transaction} |
| epoch_start | output | 1 | High in the first cycle of each epoch |
| flit_golden | output | 1 | Presented flit belongs to the golden packet |
| flit_key | output | 4 | Priority key for the arbiter; larger wins |

## Verification
The assertions assume that reset is held for at least one clock edge, so that the timer and ID start from zero together. They also assume the header inputs are stable between the driving edge and the sampling point, because the golden flag and key are purely combinational from them.

The stimulus changes header inputs only at the falling edge. It mixes several kinds of header:
- headers that match the golden ID exactly;
- headers that miss by one in the transaction field only, or in the sender field only;
- matching headers presented with valid low.

Mixing these shows that classification neither leaks into the timer nor fires on a partial match. The run covers a full rotation past the 255→0 wrap and includes a reset in the middle of an epoch.

// File: rtl/golden_sel.sv
module golden_sel #(
  parameter int SND_W   = 4,
  parameter int TXN_W   = 4,
  parameter int SEQ_W   = 3,
  parameter int EPOCH_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hdr_valid,
  input  logic [SND_W-1:0]         hdr_sender,
  input  logic [TXN_W-1:0]         hdr_txn,
  input  logic [SEQ_W-1:0]         hdr_seq,
  output logic [SND_W+TXN_W-1:0]   gold_id,
  output logic                     epoch_start,
  output logic                     flit_golden,
  output logic [SEQ_W:0]           flit_key
);

  localparam int ID_W = SND_W + TXN_W;
  localparam logic [EPOCH_W-1:0] EP_LAST = {EPOCH_W{1'b1}};

  logic [EPOCH_W-1:0] ep_cnt;
  logic               ep_wrap;

  assign ep_wrap = (ep_cnt == EP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_cnt  <= '0;
      gold_id <= '0;
    end else begin
      ep_cnt <= ep_cnt + 1'b1;
      if (ep_wrap)
        gold_id <= gold_id + 1'b1;
    end
  end

  assign epoch_start = (ep_cnt == '0);
  assign flit_golden = hdr_valid && ({hdr_sender, hdr_txn} == gold_id);
  assign flit_key    = flit_golden ? {1'b1, ~hdr_seq} : '0;

  // R2
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_wrap |=> $stable(gold_id));

  // R3
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_wrap |=> gold_id == ID_W'($past(gold_id) + 1'b1));

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_start |=> !epoch_start);

  // R4
  pulse_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_wrap |=> epoch_start);

  // R6
  key_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flit_golden |-> flit_key == '0);

  // R5
  golden_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_golden |-> hdr_valid);

endmodule

// File: tb/sim_golden_sel.sv
module sim_golden_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [3:0] hdr_sender = '0;
  logic [3:0] hdr_txn = '0;
  logic [2:0] hdr_seq = '0;
  logic [7:0] gold_id;
  logic       epoch_start;
  logic       flit_golden;
  logic [3:0] flit_key;

  always #4 clk = ~clk;

  golden_sel u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_sender(hdr_sender),
    .hdr_txn(hdr_txn), .hdr_seq(hdr_seq), .gold_id(gold_id),
    .epoch_start(epoch_start), .flit_golden(flit_golden), .flit_key(flit_key)
  );

  typedef struct packed {
    logic       in_rst;
    logic       hv;
    logic [7:0] id;
    logic       es;
    logic       g;
    logic [3:0] key;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  int k = 0;
  bit done = 0;

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (gold_id !== e.id) begin
        mismatched++;
        $display("FAIL %s gold_id: got %0d expected %0d",
                 e.in_rst ? "R1" : (e.hv ? "R7/R3" : "R2/R3"), gold_id, e.id);
      end
      compared++;
      if (epoch_start !== e.es) begin
        mismatched++;
        $display("FAIL %s epoch_start: got %0b expected %0b",
                 e.in_rst ? "R1" : (e.hv ? "R7/R4" : "R4"), epoch_start, e.es);
      end
      if (!e.in_rst) begin
        compared++;
        if (flit_golden !== e.g) begin
          mismatched++;
          $display("FAIL R5 flit_golden: got %0b expected %0b", flit_golden, e.g);
        end
        compared++;
        if (flit_key !== e.key) begin
          mismatched++;
          $display("FAIL R6 flit_key: got %0h expected %0h", flit_key, e.key);
        end
      end
    end
  end

  function automatic logic [7:0] exp_id(int n);
    return 8'((n / 64) % 256);
  endfunction

  // mode: 0 idle, 1 exact match, 2 txn off by one, 3 sender off by one, 4 match with valid low
  task automatic step(int mode, logic [2:0] sq);
    exp_t e;
    logic [7:0] id;
    id = exp_id(k);
    hdr_seq = sq;
    hdr_valid = (mode == 1 || mode == 2 || mode == 3);
    hdr_sender = id[7:4] + ((mode == 3) ? 4'd1 : 4'd0);
    hdr_txn = id[3:0] + ((mode == 2) ? 4'd1 : 4'd0);
    e.in_rst = 1'b0;
    e.hv = hdr_valid;
    e.id = id;
    e.es = ((k % 64) == 0);
    e.g = (mode == 1);
    e.key = (mode == 1) ? {1'b1, ~sq} : 4'h0;
    q.push_back(e);
    @(negedge clk);
    k++;
  endtask

  task automatic do_reset();
    exp_t e;
    rst_n = 1'b0;
    hdr_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R1: state while held in reset (after at least one edge)
      e.in_rst = 1'b1; e.hv = 1'b0; e.id = 8'd0; e.es = 1'b1; e.g = 1'b0; e.key = 4'h0;
      q.push_back(e);
    end
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
  endtask

  initial begin
    fork
      begin
        do_reset();
        for (int i = 0; i < 16384 + 300; i++)
          step(i % 5, 3'(i * 3));
        for (int i = 0; i < 37; i++)
          step(1, 3'(i));
        do_reset();
        for (int i = 0; i < 200; i++)
          step((i % 2) ? 1 : 4, 3'(7 - (i % 8)));
        done = 1;
      end
      begin
        repeat (40000) @(posedge clk);
        if (!done) begin
          mismatched++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule